// File: doc/BRIEF.md
# Interrupt Vector Ring Writer

This block takes interrupt events from on-chip clients, packs each event into a 128-bit vector, and writes that vector into a circular buffer in memory through a valid/ready write-request port. The block then holds a level interrupt towards the host. Both ring pointers count bytes. Every vector moves the write pointer forward by 16 bytes. The ring size is programmed as the log2 of the ring's size in 32-bit words. The host drains the entries and writes its read pointer back. The ring is empty when the two pointers match.

Two policies are available when the ring fills. With overflow detection off, the event port stalls until the host frees a slot. With overflow detection on, the writer keeps going and overwrites the oldest entry. In that case it sets a sticky flag in bit 0 of the reported write pointer, and the oldest intact entry is then at (wptr + 16) & mask. As an option, each pointer update can be mirrored to a 40-bit writeback address, so the host can poll memory instead of registers. Clearing the enable bits stops vector writes, and software then zeroes the pointers.

Top module: `ivr_writer`

## Requirements
- R1: Each vector carries the source id in bits [7:0], the 28-bit source data in [59:32], the ring id in [71:64], the VMID in [79:72] and the PASID in [95:80]. Every other bit is zero.
- R2: A vector is written to address ({BASE, 8'h00} + wptr), which is 40 bits wide. While mem_ready is low, mem_valid, mem_addr and mem_data hold steady.
- R3: The write pointer grows by 16 per vector and wraps modulo the ring size. The ring size in bytes is 4 << SIZE, where SIZE is CTRL bits [5:1] and SIZE is at least 2.
- R4: With CTRL bit 0 (ring enable) clear, ev_ready stays low and no memory write is issued.
- R5: With CTRL bit 6 (overflow detection) clear, ev_ready is low while ((wptr + 16) & mask) == rptr. The port accepts again once the host moves rptr on.
- R6: With CTRL bit 6 set, an event that arrives on a full ring is still written. That write sets an overflow flag, which reads back as bit 0 of register 3.
- R7: The overflow flag stays set until a write to CTRL has bit 7 set. A CTRL write without bit 7 leaves the flag as it was.
- R8: With CTRL bit 8 set, each vector write is followed by a second write with mem_wb=1. That write goes to {WBHI[7:0], WBLO} and carries the new wptr, with the overflow flag in bit 0, in data bits [31:0]. All other data bits are zero.
- R9: The irq output is a register. It is high one cycle after int_en (CTRL bit 9) is set and either rptr differs from wptr or the overflow flag is set. Otherwise it is low.
- R10: The busy output is a register. It is high one cycle after either a memory write is pending or int_en is set with rptr differing from wptr.
- R11: Reads return data one cycle after cfg_addr is presented. The addresses are 0 CTRL (bit 7 reads 0), 1 BASE, 2 RPTR, 3 WPTR with the overflow flag in bit 0, 4 WBLO and 5 WBHI (8 bits).
- R12: Writes to address 2 or 3 load rptr or wptr. The written value is masked to the ring size and forced to 16-byte alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Event offered |
| ev_ready | output | 1 | Event accepted on this edge when valid |
| ev_src | input | 8 | Event source id |
| ev_data | input | 28 | Event source data |
| ev_ring | input | 8 | Event ring id |
| ev_vmid | input | 8 | Event VMID |
| ev_pasid | input | 16 | Event PASID |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory write accepted |
| mem_addr | output | 40 | Memory byte address |
| mem_data | output | 128 | Memory write data |
| mem_wb | output | 1 | High for a pointer writeback, low for a vector |
| irq | output | 1 | Level interrupt to host |
| busy | output | 1 | Block busy status |

## Verification
The bench builds the block with its default 18-bit pointers. It programs SIZE=4, which gives a 64-byte ring with four slots. At that size, wrap, full stall and overrun all occur within a handful of events. One scenario holds mem_ready low for several cycles so that request hold and busy can be observed. The writeback scenario includes an overflowed pointer, so the flag is checked on its way to memory.

// File: rtl/ivr_pkg.sv
package ivr_pkg;
  localparam int VEC_W     = 128;
  localparam int VEC_BYTES = 16;

  typedef enum logic [1:0] {ST_IDLE, ST_VEC, ST_WB} wr_state_t;

  typedef struct packed {
    logic [15:0] pasid;
    logic [7:0]  vmid;
    logic [7:0]  ring;
    logic [27:0] data;
    logic [7:0]  src;
  } ivr_event_t;

  // register indices
  localparam logic [2:0] RA_CTRL = 3'd0;
  localparam logic [2:0] RA_BASE = 3'd1;
  localparam logic [2:0] RA_RPTR = 3'd2;
  localparam logic [2:0] RA_WPTR = 3'd3;
  localparam logic [2:0] RA_WBLO = 3'd4;
  localparam logic [2:0] RA_WBHI = 3'd5;

  // control bit positions
  localparam int CB_RING_EN = 0;
  localparam int CB_SIZE_LO = 1;
  localparam int CB_OVF_EN  = 6;
  localparam int CB_OVF_CLR = 7;
  localparam int CB_WB_EN   = 8;
  localparam int CB_INT_EN  = 9;

  function automatic logic [VEC_W-1:0] pack_vector(input ivr_event_t e);
    logic [VEC_W-1:0] v;
    v        = '0;
    v[7:0]   = e.src;
    v[59:32] = e.data;
    v[71:64] = e.ring;
    v[79:72] = e.vmid;
    v[95:80] = e.pasid;
    return v;
  endfunction
endpackage

// File: rtl/ivr_regs.sv
module ivr_regs
  import ivr_pkg::*;
#(
  parameter int PTR_W  = 18,
  parameter int SZ_W   = 5,
  parameter int ADDR_W = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic [PTR_W-1:0]  ptr_mask,
  input  logic [PTR_W-1:0]  wptr_in,
  input  logic              ovf_in,
  output logic              ring_en,
  output logic              int_en,
  output logic              ovf_en,
  output logic              wb_en,
  output logic [SZ_W-1:0]   size_log2,
  output logic [31:0]       base_q,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [PTR_W-1:0]  rptr,
  output logic              wptr_we,
  output logic [PTR_W-1:0]  wptr_wval,
  output logic              ovf_clr
);
  localparam int WBHI_W = ADDR_W - 32;

  logic [31:0]       wb_lo;
  logic [WBHI_W-1:0] wb_hi;
  logic [31:0]       ctrl_view;
  logic              wr_ctrl;

  assign wr_ctrl   = cfg_we && (cfg_addr == RA_CTRL);
  assign wptr_we   = cfg_we && (cfg_addr == RA_WPTR);
  assign wptr_wval = cfg_wdata[PTR_W-1:0] & ptr_mask;
  assign ovf_clr   = wr_ctrl && cfg_wdata[CB_OVF_CLR];
  assign wb_addr   = {wb_hi, wb_lo};

  always_comb begin
    ctrl_view                        = '0;
    ctrl_view[CB_RING_EN]            = ring_en;
    ctrl_view[CB_SIZE_LO +: SZ_W]    = size_log2;
    ctrl_view[CB_OVF_EN]             = ovf_en;
    ctrl_view[CB_WB_EN]              = wb_en;
    ctrl_view[CB_INT_EN]             = int_en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ring_en   <= 1'b0;
      int_en    <= 1'b0;
      ovf_en    <= 1'b0;
      wb_en     <= 1'b0;
      size_log2 <= '0;
      base_q    <= '0;
      wb_lo     <= '0;
      wb_hi     <= '0;
      rptr      <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        RA_CTRL: begin
          ring_en   <= cfg_wdata[CB_RING_EN];
          size_log2 <= cfg_wdata[CB_SIZE_LO +: SZ_W];
          ovf_en    <= cfg_wdata[CB_OVF_EN];
          wb_en     <= cfg_wdata[CB_WB_EN];
          int_en    <= cfg_wdata[CB_INT_EN];
        end
        RA_BASE: base_q <= cfg_wdata;
        RA_RPTR: rptr   <= cfg_wdata[PTR_W-1:0] & ptr_mask;
        RA_WBLO: wb_lo  <= cfg_wdata;
        RA_WBHI: wb_hi  <= cfg_wdata[WBHI_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else begin
      case (cfg_addr)
        RA_CTRL: cfg_rdata <= ctrl_view;
        RA_BASE: cfg_rdata <= base_q;
        RA_RPTR: cfg_rdata <= 32'(rptr);
        RA_WPTR: cfg_rdata <= 32'(wptr_in) | {31'b0, ovf_in};
        RA_WBLO: cfg_rdata <= wb_lo;
        RA_WBHI: cfg_rdata <= 32'(wb_hi);
        default: cfg_rdata <= '0;
      endcase
    end
  end

  // R12: rptr only moves through a register write
  p_rptr_sw_only_r12: assert property (@(posedge clk) disable iff (rst)
    !(cfg_we && cfg_addr == RA_RPTR) |=> $stable(rptr));
endmodule

// File: rtl/ivr_ptr.sv
module ivr_ptr
  import ivr_pkg::*;
#(
  parameter int PTR_W = 18,
  parameter int SZ_W  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SZ_W-1:0]  size_log2,
  input  logic [PTR_W-1:0] rptr,
  input  logic             ovf_en,
  input  logic             advance,
  input  logic             sw_we,
  input  logic [PTR_W-1:0] sw_val,
  input  logic             ovf_clr,
  output logic [PTR_W-1:0] wptr,
  output logic             ovf,
  output logic [PTR_W-1:0] mask,
  output logic             full,
  output logic             empty,
  output logic [PTR_W-1:0] wptr_next,
  output logic             ovf_next
);
  localparam int ALIGN_BITS = $clog2(VEC_BYTES);

  // byte mask: bits from the entry alignment up to log2(ring bytes)
  always_comb begin
    for (int i = 0; i < PTR_W; i++)
      mask[i] = (i >= ALIGN_BITS) && (i < (int'(size_log2) + 2));
  end

  assign wptr_next = (wptr + PTR_W'(VEC_BYTES)) & mask;
  assign full      = (wptr_next == rptr);
  assign empty     = (wptr == rptr);
  assign ovf_next  = ovf || (ovf_en && full);

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      ovf  <= 1'b0;
    end else begin
      if (advance)    wptr <= wptr_next;
      else if (sw_we) wptr <= sw_val;
      if (advance && ovf_en && full) ovf <= 1'b1;
      else if (ovf_clr)              ovf <= 1'b0;
    end
  end

  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    ovf && !ovf_clr |=> ovf);
  p_wptr_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !advance && !sw_we |=> $stable(wptr));
endmodule

// File: rtl/ivr_mem_fsm.sv
module ivr_mem_fsm
  import ivr_pkg::*;
#(
  parameter int PTR_W  = 18,
  parameter int ADDR_W = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_valid,
  input  ivr_event_t        ev,
  output logic              ev_ready,
  input  logic              ring_en,
  input  logic              room,
  input  logic [31:0]       base_q,
  input  logic [PTR_W-1:0]  wptr,
  input  logic              wb_en,
  input  logic [ADDR_W-1:0] wb_addr,
  input  logic [PTR_W-1:0]  wptr_next,
  input  logic              ovf_next,
  input  logic              mem_ready,
  output logic              mem_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [VEC_W-1:0]  mem_data,
  output logic              mem_wb,
  output logic              advance,
  output logic              active
);
  wr_state_t         state;
  logic [ADDR_W-1:0] ring_base;
  logic [31:0]       wb_word;

  assign ring_base = ADDR_W'({base_q, 8'h00});
  assign wb_word   = 32'(wptr_next) | {31'b0, ovf_next};
  assign ev_ready  = (state == ST_IDLE) && ring_en && room;
  assign advance   = (state == ST_VEC) && mem_ready;
  assign active    = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      mem_valid <= 1'b0;
      mem_addr  <= '0;
      mem_data  <= '0;
      mem_wb    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (ev_valid && ev_ready) begin
          state     <= ST_VEC;
          mem_valid <= 1'b1;
          mem_wb    <= 1'b0;
          mem_addr  <= ring_base + ADDR_W'(wptr);
          mem_data  <= pack_vector(ev);
        end
        ST_VEC: if (mem_ready) begin
          if (wb_en) begin
            state    <= ST_WB;
            mem_addr <= wb_addr;
            mem_data <= VEC_W'(wb_word);
            mem_wb   <= 1'b1;
          end else begin
            state     <= ST_IDLE;
            mem_valid <= 1'b0;
          end
        end
        ST_WB: if (mem_ready) begin
          state     <= ST_IDLE;
          mem_valid <= 1'b0;
          mem_wb    <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_mem_hold_r2: assert property (@(posedge clk) disable iff (rst)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data));
  p_accept_issues_r2: assert property (@(posedge clk) disable iff (rst)
    ev_valid && ev_ready |=> mem_valid && !mem_wb);
  p_wb_follows_vec_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_wb) |-> $past(mem_valid) && !$past(mem_wb));
endmodule

// File: rtl/ivr_writer.sv
module ivr_writer
  import ivr_pkg::*;
#(
  parameter int PTR_W  = 18,
  parameter int SZ_W   = 5,
  parameter int ADDR_W = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic [7:0]        ev_src,
  input  logic [27:0]       ev_data,
  input  logic [7:0]        ev_ring,
  input  logic [7:0]        ev_vmid,
  input  logic [15:0]       ev_pasid,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [127:0]      mem_data,
  output logic              mem_wb,
  output logic              irq,
  output logic              busy
);
  logic              ring_en, int_en, ovf_en, wb_en;
  logic [SZ_W-1:0]   size_log2;
  logic [31:0]       base_q;
  logic [ADDR_W-1:0] wb_addr;
  logic [PTR_W-1:0]  rptr, wptr, mask, wptr_next, wptr_wval;
  logic              wptr_we, ovf_clr, ovf, full, empty, ovf_next;
  logic              advance, active;
  ivr_event_t        ev;

  assign ev = '{pasid: ev_pasid, vmid: ev_vmid, ring: ev_ring, data: ev_data, src: ev_src};

  ivr_regs #(.PTR_W(PTR_W), .SZ_W(SZ_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ptr_mask(mask),
    .wptr_in(wptr), .ovf_in(ovf), .ring_en(ring_en), .int_en(int_en),
    .ovf_en(ovf_en), .wb_en(wb_en), .size_log2(size_log2), .base_q(base_q),
    .wb_addr(wb_addr), .rptr(rptr), .wptr_we(wptr_we), .wptr_wval(wptr_wval),
    .ovf_clr(ovf_clr)
  );

  ivr_ptr #(.PTR_W(PTR_W), .SZ_W(SZ_W)) u_ptr (
    .clk(clk), .rst(rst), .size_log2(size_log2), .rptr(rptr), .ovf_en(ovf_en),
    .advance(advance), .sw_we(wptr_we), .sw_val(wptr_wval), .ovf_clr(ovf_clr),
    .wptr(wptr), .ovf(ovf), .mask(mask), .full(full), .empty(empty),
    .wptr_next(wptr_next), .ovf_next(ovf_next)
  );

  ivr_mem_fsm #(.PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_fsm (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev(ev), .ev_ready(ev_ready),
    .ring_en(ring_en), .room(ovf_en || !full), .base_q(base_q), .wptr(wptr),
    .wb_en(wb_en), .wb_addr(wb_addr), .wptr_next(wptr_next), .ovf_next(ovf_next),
    .mem_ready(mem_ready), .mem_valid(mem_valid), .mem_addr(mem_addr),
    .mem_data(mem_data), .mem_wb(mem_wb), .advance(advance), .active(active)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq  <= 1'b0;
      busy <= 1'b0;
    end else begin
      irq  <= int_en && (!empty || ovf);
      busy <= active || (int_en && !empty);
    end
  end

  p_stall_full_r5: assert property (@(posedge clk) disable iff (rst)
    ev_valid && ev_ready && !ovf_en |-> !full);
  p_disabled_r4: assert property (@(posedge clk) disable iff (rst)
    !ring_en && !mem_valid |=> !mem_valid);
endmodule

// File: tb/ivr_writer_test.sv
module ivr_writer_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         ev_valid = 1'b0;
  logic         ev_ready;
  logic [7:0]   ev_src = '0;
  logic [27:0]  ev_data = '0;
  logic [7:0]   ev_ring = '0;
  logic [7:0]   ev_vmid = '0;
  logic [15:0]  ev_pasid = '0;
  logic         cfg_we = 1'b0;
  logic [2:0]   cfg_addr = '0;
  logic [31:0]  cfg_wdata = '0;
  logic [31:0]  cfg_rdata;
  logic         mem_valid;
  logic         mem_ready = 1'b1;
  logic [39:0]  mem_addr;
  logic [127:0] mem_data;
  logic         mem_wb;
  logic         irq;
  logic         busy;

  int n_chk = 0;
  int n_fail = 0;
  int mr_mode = 0;
  int cap_n = 0;
  logic [39:0]  cap_addr [64];
  logic [127:0] cap_data [64];
  logic         cap_wb   [64];

  always #4 clk = ~clk;

  ivr_writer uut (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_src(ev_src), .ev_data(ev_data), .ev_ring(ev_ring), .ev_vmid(ev_vmid),
    .ev_pasid(ev_pasid), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
    .mem_wb(mem_wb), .irq(irq), .busy(busy)
  );

  always @(negedge clk) mem_ready <= (mr_mode == 0);

  always @(posedge clk) begin
    if (!rst && mem_valid && mem_ready && cap_n < 64) begin
      cap_addr[cap_n] = mem_addr;
      cap_data[cap_n] = mem_data;
      cap_wb[cap_n]   = mem_wb;
      cap_n           = cap_n + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    @(negedge clk);
    d = cfg_rdata;
  endtask

  task automatic send_event(input logic [7:0] s, input logic [27:0] d, input logic [7:0] r,
                            input logic [7:0] v, input logic [15:0] p);
    int waited;
    waited = 0;
    @(negedge clk);
    ev_src = s; ev_data = d; ev_ring = r; ev_vmid = v; ev_pasid = p;
    ev_valid = 1'b1;
    while (!ev_ready && waited < 50) begin
      @(negedge clk);
      waited++;
    end
    chk(ev_ready, "R5 event acceptance", {127'b0, ev_ready}, 128'd1);
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic wait_caps(input int n);
    int waited;
    waited = 0;
    while (cap_n < n && waited < 100) begin
      @(negedge clk);
      waited++;
    end
    chk(cap_n >= n, "R2 memory write issued", 128'(cap_n), 128'(n));
  endtask

  function automatic logic [127:0] exp_vec(input logic [7:0] s, input logic [27:0] d,
                                           input logic [7:0] r, input logic [7:0] v,
                                           input logic [15:0] p);
    logic [127:0] e;
    e = '0;
    e[7:0] = s; e[59:32] = d; e[71:64] = r; e[79:72] = v; e[95:80] = p;
    return e;
  endfunction

  // R4 R11: reset state and disabled ring
  task automatic t_reset();
    logic [31:0] rd;
    cfg_read(3'd3, rd);
    chk(rd == 32'h0, "R11 WPTR after reset", 128'(rd), 128'h0);
    chk(!irq && !busy, "R9 R10 idle after reset", {126'b0, irq, busy}, 128'h0);
    chk(!ev_ready, "R4 ready low when ring disabled", 128'(ev_ready), 128'h0);
  endtask

  task automatic t_config();
    logic [31:0] rd;
    cfg_write(3'd0, 32'h209);
    cfg_write(3'd1, 32'h12);
    cfg_read(3'd0, rd);
    chk(rd == 32'h209, "R11 CTRL readback", 128'(rd), 128'h209);
    cfg_read(3'd1, rd);
    chk(rd == 32'h12, "R11 BASE readback", 128'(rd), 128'h12);
  endtask

  // R1 R2 R3 R9 R10: one vector
  task automatic t_basic();
    logic [31:0] rd;
    send_event(8'h5A, 28'hABCDEF1, 8'h33, 8'h07, 16'hBEEF);
    wait_caps(1);
    chk(cap_data[0] == exp_vec(8'h5A, 28'hABCDEF1, 8'h33, 8'h07, 16'hBEEF), "R1 vector layout",
        cap_data[0], exp_vec(8'h5A, 28'hABCDEF1, 8'h33, 8'h07, 16'hBEEF));
    chk(cap_addr[0] == 40'h1200 && !cap_wb[0], "R2 vector address", 128'(cap_addr[0]), 128'h1200);
    cfg_read(3'd3, rd);
    chk(rd == 32'h10, "R3 wptr advance by 16", 128'(rd), 128'h10);
    chk(irq, "R9 irq with pending entry", 128'(irq), 128'h1);
    chk(busy, "R10 busy with pending entry", 128'(busy), 128'h1);
    cfg_write(3'd2, 32'h10);
    @(negedge clk);
    chk(!irq, "R9 irq drops once drained", 128'(irq), 128'h0);
    chk(!busy, "R10 busy drops once drained", 128'(busy), 128'h0);
  endtask

  // R2 R10: request held under back-pressure
  task automatic t_stall_mem();
    logic [39:0] a0;
    mr_mode = 1;
    send_event(8'hC3, 28'h0000001, 8'h00, 8'hFF, 16'h0001);
    a0 = mem_addr;
    repeat (3) @(negedge clk);
    chk(mem_valid && mem_addr == a0 && a0 == 40'h1210, "R2 hold under stall", 128'(mem_addr), 128'h1210);
    chk(busy, "R10 busy while write pending", 128'(busy), 128'h1);
    chk(cap_n == 1, "R2 no handshake while stalled", 128'(cap_n), 128'h1);
    mr_mode = 0;
    wait_caps(2);
    chk(cap_data[1] == exp_vec(8'hC3, 28'h1, 8'h0, 8'hFF, 16'h1), "R1 second vector",
        cap_data[1], exp_vec(8'hC3, 28'h1, 8'h0, 8'hFF, 16'h1));
  endtask

  // R12: pointer writes masked and aligned
  task automatic t_ptrs();
    logic [31:0] rd;
    cfg_write(3'd3, 32'h35);
    cfg_read(3'd3, rd);
    chk(rd == 32'h30, "R12 WPTR write masked", 128'(rd), 128'h30);
    cfg_write(3'd2, 32'h1F);
    cfg_read(3'd2, rd);
    chk(rd == 32'h10, "R12 RPTR write masked", 128'(rd), 128'h10);
    cfg_write(3'd3, 32'h0);
    cfg_write(3'd2, 32'h0);
  endtask

  // R5 R3: full stall then wrap
  task automatic t_full_wrap();
    logic [31:0] rd;
    int c0;
    send_event(8'h01, 28'h1, 8'h1, 8'h1, 16'h1);
    send_event(8'h02, 28'h2, 8'h2, 8'h2, 16'h2);
    send_event(8'h03, 28'h3, 8'h3, 8'h3, 16'h3);
    wait_caps(5);
    @(negedge clk);
    chk(!ev_ready, "R5 ready low on full ring", 128'(ev_ready), 128'h0);
    c0 = cap_n;
    ev_valid = 1'b1;
    repeat (4) @(negedge clk);
    ev_valid = 1'b0;
    chk(cap_n == c0, "R5 no write while full", 128'(cap_n), 128'(c0));
    cfg_write(3'd2, 32'h10);
    chk(ev_ready, "R5 ready after rptr moves", 128'(ev_ready), 128'h1);
    send_event(8'h04, 28'h4, 8'h4, 8'h4, 16'h4);
    wait_caps(6);
    chk(cap_addr[5] == 40'h1230, "R3 last slot address", 128'(cap_addr[5]), 128'h1230);
    cfg_read(3'd3, rd);
    chk(rd == 32'h0, "R3 wptr wraps to zero", 128'(rd), 128'h0);
  endtask

  // R6 R7 R9 R11: overflow
  task automatic t_overflow();
    logic [31:0] rd;
    cfg_write(3'd0, 32'h249);
    send_event(8'h05, 28'h5, 8'h5, 8'h5, 16'h5);
    wait_caps(7);
    chk(cap_addr[6] == 40'h1200, "R6 overrun still written", 128'(cap_addr[6]), 128'h1200);
    cfg_read(3'd3, rd);
    chk(rd == 32'h11, "R6 overflow flag in WPTR", 128'(rd), 128'h11);
    chk(irq, "R9 irq held by overflow", 128'(irq), 128'h1);
    send_event(8'h06, 28'h6, 8'h6, 8'h6, 16'h6);
    wait_caps(8);
    cfg_write(3'd0, 32'h249);
    cfg_read(3'd3, rd);
    chk(rd == 32'h21, "R7 flag survives CTRL write", 128'(rd), 128'h21);
    cfg_write(3'd0, 32'h2C9);
    cfg_read(3'd3, rd);
    chk(rd == 32'h20, "R7 flag cleared by bit 7", 128'(rd), 128'h20);
    cfg_read(3'd0, rd);
    chk(rd == 32'h249, "R11 CTRL bit 7 reads zero", 128'(rd), 128'h249);
  endtask

  // R8 R11: writeback
  task automatic t_writeback();
    logic [31:0] rd;
    cfg_write(3'd4, 32'h1000_0040);
    cfg_write(3'd5, 32'h1AB);
    cfg_read(3'd5, rd);
    chk(rd == 32'hAB, "R11 WBHI 8-bit readback", 128'(rd), 128'hAB);
    cfg_read(3'd4, rd);
    chk(rd == 32'h1000_0040, "R11 WBLO readback", 128'(rd), 128'h10000040);
    cfg_write(3'd2, 32'h20);
    cfg_write(3'd0, 32'h349);
    send_event(8'h07, 28'h7, 8'h7, 8'h7, 16'h7);
    wait_caps(10);
    chk(cap_addr[8] == 40'h1220 && !cap_wb[8], "R8 vector before writeback", 128'(cap_addr[8]), 128'h1220);
    chk(cap_wb[9] && cap_addr[9] == 40'hAB_1000_0040, "R8 writeback address", 128'(cap_addr[9]), 128'hAB10000040);
    chk(cap_data[9] == 128'h30, "R8 writeback data", cap_data[9], 128'h30);
    cfg_write(3'd2, 32'h0);
    send_event(8'h08, 28'h8, 8'h8, 8'h8, 16'h8);
    wait_caps(12);
    chk(cap_wb[11] && cap_data[11] == 128'h1, "R8 writeback carries overflow", cap_data[11], 128'h1);
  endtask

  // R4 R9 R12: disable and reset pointers
  task automatic t_disable();
    logic [31:0] rd;
    int c0;
    cfg_write(3'd0, 32'h0);
    @(negedge clk);
    chk(!irq, "R9 irq low with int_en clear", 128'(irq), 128'h0);
    c0 = cap_n;
    ev_valid = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk(!ev_ready, "R4 ready low when disabled", 128'(ev_ready), 128'h0);
    end
    ev_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk(cap_n == c0, "R4 no write when disabled", 128'(cap_n), 128'(c0));
    cfg_write(3'd0, 32'h80);
    cfg_write(3'd3, 32'h0);
    cfg_write(3'd2, 32'h0);
    cfg_read(3'd3, rd);
    chk(rd == 32'h0, "R12 pointers zeroed", 128'(rd), 128'h0);
    chk(!busy, "R10 idle after disable", 128'(busy), 128'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_config();
    t_basic();
    t_stall_mem();
    t_ptrs();
    t_full_wrap();
    t_overflow();
    t_writeback();
    t_disable();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule